// File: doc/BRIEF.md
# Command Ring Packet Parser

The parser walks a circular buffer of 32-bit command words that software fills. Software publishes new words by moving a write index forward; the parser reads the word under its own read index whenever the two indices differ. It moves the read index forward one slot for each word it uses up. Both indices wrap at the ring size, which is a power of two.

Each packet begins with a header word, and bits [31:30] of that word give the packet kind. A register-burst packet turns its data words into writes to consecutive register addresses. A filler word is dropped without a trace. An operation packet carries an opcode and a predicate flag, and its payload words go out on an operation port together with that opcode and flag. The parser does not execute the operations.

Both output ports use a valid/ready handshake. The parser waits when a port is not ready, and it also waits when the ring runs dry in the middle of a packet. The read index is brought out so that software can see how far the parser has got.

Top module: `cmdring_parser`

## Requirements
- R1: After reset the read index is 0. `rw_valid_o`, `op_valid_o` and `bad_hdr_o` are all low.
- R2: While the read index equals the write index, no word is consumed, both valid outputs are low and the read index holds. This also applies in the middle of a packet: the packet resumes once more words are published.
- R3: A header with kind 0 (bits [31:30] = 2'b00) is followed by N+1 data words, where N is bits [29:16]. Data word i is written to register address (bits [15:0] + i) mod 2^16, in ring order.
- R4: A word with kind 2 (bits [31:30] = 2'b10) is consumed as one word and produces no output on either port.
- R5: A header with kind 3 (bits [31:30] = 2'b11) carries an opcode in bits [15:8], a predicate in bit 0 and a payload count minus one in bits [29:16]. Each payload word is sent with that opcode and predicate. `op_last_o` is high on the final payload word only.
- R6: A word with kind 1 (bits [31:30] = 2'b01) raises `bad_hdr_o` for the one cycle in which it is consumed. Its other bits are ignored, and the next word is parsed as a header.
- R7: The read index wraps from 2^IDX_W-1 to 0. A packet that crosses the end of the ring continues at slot 0 without any loss.
- R8: While a valid output is high and its ready input is low, the address, data, opcode, predicate and last outputs hold steady, and the read index does not move.
- R9: The read index moves by exactly one slot for each consumed word, whether header or data, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_idx_i | input | IDX_W | Write index advanced by software |
| rd_idx_o | output | IDX_W | Read index of the next word to consume |
| mem_addr_o | output | IDX_W | Ring slot being read |
| mem_word_i | input | 32 | Word at `mem_addr_o` (combinational read) |
| rw_valid_o | output | 1 | Register write available |
| rw_ready_i | input | 1 | Register write accepted |
| rw_addr_o | output | 16 | Register address |
| rw_data_o | output | 32 | Register data |
| op_valid_o | output | 1 | Operation payload word available |
| op_ready_i | input | 1 | Operation payload word accepted |
| op_code_o | output | 8 | Opcode of the current operation packet |
| op_pred_o | output | 1 | Predicate flag of the current operation packet |
| op_last_o | output | 1 | Final payload word of the packet |
| op_data_o | output | 32 | Payload word |
| bad_hdr_o | output | 1 | One-cycle pulse when a reserved header is skipped |

## Verification
The main function is tried with several input patterns, each aimed at a different fault:
- A burst whose data words arrive in two separate publishes shows whether the parser stalls on an empty ring mid-packet rather than reading stale slots.
- A burst based at 0xFFFE exposes address-increment width errors.
- Runs of filler words that end exactly at the ring boundary, and an operation packet that straddles slot 0, separate the wrap logic from the per-kind decoding.
- A reserved header with a nonzero length field, and traffic sent while ready toggles, show whether that field is ignored and whether stalls drop, repeat or reorder words.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 14;
  localparam int RADDR_W = 16;
  localparam int OPC_W   = 8;

  typedef enum logic [1:0] {
    PK_REGS = 2'd0,
    PK_RSVD = 2'd1,
    PK_FILL = 2'd2,
    PK_OPER = 2'd3
  } pkt_kind_e;

  typedef struct packed {
    pkt_kind_e            kind;
    logic [CNT_W-1:0]     len_m1;
    logic [RADDR_W-1:0]   base;
    logic [OPC_W-1:0]     opcode;
    logic                 pred;
  } hdr_t;

  // Field split of a header word.
  function automatic hdr_t decode_hdr(input logic [WORD_W-1:0] w);
    hdr_t h;
    h.kind   = pkt_kind_e'(w[31:30]);
    h.len_m1 = w[29:16];
    h.base   = w[15:0];
    h.opcode = w[15:8];
    h.pred   = w[0];
    return h;
  endfunction

  // Register address of a burst after one accepted write.
  function automatic logic [RADDR_W-1:0] next_reg(input logic [RADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/cmdring_rdptr.sv
module cmdring_rdptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] rd_idx
);
  // Power-of-two ring: the natural carry-out is the wrap.
  always_ff @(posedge clk) begin
    if (!rst_n)    rd_idx <= '0;
    else if (step) rd_idx <= rd_idx + 1'b1;
  end
endmodule

// File: rtl/cmdring_hdr_dec.sv
module cmdring_hdr_dec
  import cmdring_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr
);
  always_comb hdr = decode_hdr(word);
endmodule

// File: rtl/cmdring_seq.sv
module cmdring_seq
  import cmdring_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               avail,
  input  hdr_t               hdr,
  input  logic [WORD_W-1:0]  word,
  input  logic               rw_ready,
  input  logic               op_ready,
  output logic               step,
  output logic               rw_valid,
  output logic [RADDR_W-1:0] rw_addr,
  output logic [WORD_W-1:0]  rw_data,
  output logic               op_valid,
  output logic [OPC_W-1:0]   op_code,
  output logic               op_pred,
  output logic               op_last,
  output logic [WORD_W-1:0]  op_data,
  output logic               bad_hdr
);
  typedef enum logic [1:0] {S_HDR, S_REGS, S_OPER} st_e;

  st_e              st;
  logic [CNT_W-1:0] remain;
  logic             hdr_take, rw_fire, op_fire, last_beat;

  assign last_beat = (remain == '0);
  assign hdr_take  = (st == S_HDR) && avail;
  assign rw_valid  = (st == S_REGS) && avail;
  assign op_valid  = (st == S_OPER) && avail;
  assign rw_fire   = rw_valid && rw_ready;
  assign op_fire   = op_valid && op_ready;
  assign bad_hdr   = hdr_take && (hdr.kind == PK_RSVD);
  assign step      = hdr_take || rw_fire || op_fire;
  assign rw_data   = word;
  assign op_data   = word;
  assign op_last   = op_valid && last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_HDR;
      remain  <= '0;
      rw_addr <= '0;
      op_code <= '0;
      op_pred <= 1'b0;
    end else if (hdr_take) begin
      unique case (hdr.kind)
        PK_REGS: begin
          st      <= S_REGS;
          remain  <= hdr.len_m1;
          rw_addr <= hdr.base;
        end
        PK_OPER: begin
          st      <= S_OPER;
          remain  <= hdr.len_m1;
          op_code <= hdr.opcode;
          op_pred <= hdr.pred;
        end
        default: st <= S_HDR;
      endcase
    end else if (rw_fire || op_fire) begin
      if (rw_fire) rw_addr <= next_reg(rw_addr);
      if (last_beat) st <= S_HDR;
      else           remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/cmdring_parser.sv
module cmdring_parser
  import cmdring_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   wr_idx_i,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic [IDX_W-1:0]   mem_addr_o,
  input  logic [WORD_W-1:0]  mem_word_i,
  output logic               rw_valid_o,
  input  logic               rw_ready_i,
  output logic [RADDR_W-1:0] rw_addr_o,
  output logic [WORD_W-1:0]  rw_data_o,
  output logic               op_valid_o,
  input  logic               op_ready_i,
  output logic [OPC_W-1:0]   op_code_o,
  output logic               op_pred_o,
  output logic               op_last_o,
  output logic [WORD_W-1:0]  op_data_o,
  output logic               bad_hdr_o
);
  logic       word_taken;
  logic       ring_avail;
  hdr_t       hdr;
  logic [IDX_W-1:0] rd_idx;

  assign ring_avail = (rd_idx != wr_idx_i);
  assign rd_idx_o   = rd_idx;
  assign mem_addr_o = rd_idx;

  cmdring_rdptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(word_taken), .rd_idx(rd_idx)
  );

  cmdring_hdr_dec u_dec (.word(mem_word_i), .hdr(hdr));

  cmdring_seq u_seq (
    .clk(clk), .rst_n(rst_n), .avail(ring_avail), .hdr(hdr), .word(mem_word_i),
    .rw_ready(rw_ready_i), .op_ready(op_ready_i), .step(word_taken),
    .rw_valid(rw_valid_o), .rw_addr(rw_addr_o), .rw_data(rw_data_o),
    .op_valid(op_valid_o), .op_code(op_code_o), .op_pred(op_pred_o),
    .op_last(op_last_o), .op_data(op_data_o), .bad_hdr(bad_hdr_o)
  );
endmodule

// File: rtl/cmdring_parser_chk.sv
module cmdring_parser_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic             word_taken,
  input logic             rw_valid_o,
  input logic             rw_ready_i,
  input logic [15:0]      rw_addr_o,
  input logic [31:0]      rw_data_o,
  input logic             op_valid_o,
  input logic             op_ready_i,
  input logic [7:0]       op_code_o,
  input logic             op_pred_o,
  input logic             op_last_o,
  input logic [31:0]      op_data_o,
  input logic             bad_hdr_o
);
  // R2
  a_r2_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_o == wr_idx_i) |-> (!rw_valid_o && !op_valid_o && !bad_hdr_o && !word_taken));

  // R9
  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_taken |=> (rd_idx_o == IDX_W'($past(rd_idx_o) + 1'b1)));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !word_taken |=> $stable(rd_idx_o));

  // R8
  a_r8_rw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_valid_o && !rw_ready_i) |=>
      (rw_valid_o && $stable(rw_addr_o) && $stable(rw_data_o) && $stable(rd_idx_o)));

  a_r8_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_o && !op_ready_i) |=>
      (op_valid_o && $stable(op_code_o) && $stable(op_pred_o) &&
       $stable(op_last_o) && $stable(op_data_o) && $stable(rd_idx_o)));

  // R5, R6: one kind of activity per cycle
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rw_valid_o, op_valid_o, bad_hdr_o}));

  // R5
  a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    op_last_o |-> op_valid_o);
endmodule

bind cmdring_parser cmdring_parser_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_idx_i(wr_idx_i), .rd_idx_o(rd_idx_o),
  .word_taken(word_taken), .rw_valid_o(rw_valid_o), .rw_ready_i(rw_ready_i),
  .rw_addr_o(rw_addr_o), .rw_data_o(rw_data_o), .op_valid_o(op_valid_o),
  .op_ready_i(op_ready_i), .op_code_o(op_code_o), .op_pred_o(op_pred_o),
  .op_last_o(op_last_o), .op_data_o(op_data_o), .bad_hdr_o(bad_hdr_o)
);

// File: tb/sim_cmdring_parser.sv
`timescale 1ns/1ps
module sim_cmdring_parser;
  localparam int IDX_W = 4;
  localparam int RING  = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [IDX_W-1:0] rd_idx, mem_addr;
  logic [31:0]      mem_word;
  logic             rw_valid, rw_ready = 1'b1;
  logic [15:0]      rw_addr;
  logic [31:0]      rw_data;
  logic             op_valid, op_ready = 1'b1;
  logic [7:0]       op_code;
  logic             op_pred, op_last;
  logic [31:0]      op_data;
  logic             bad_hdr;

  logic [31:0] ring [RING];
  assign mem_word = ring[mem_addr];

  always #4 clk = ~clk;

  cmdring_parser #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_idx_i(wr_idx), .rd_idx_o(rd_idx),
    .mem_addr_o(mem_addr), .mem_word_i(mem_word),
    .rw_valid_o(rw_valid), .rw_ready_i(rw_ready), .rw_addr_o(rw_addr), .rw_data_o(rw_data),
    .op_valid_o(op_valid), .op_ready_i(op_ready), .op_code_o(op_code), .op_pred_o(op_pred),
    .op_last_o(op_last), .op_data_o(op_data), .bad_hdr_o(bad_hdr)
  );

  int checks = 0, errors = 0;
  int wp = 0;
  bit stall_en = 1'b0;
  int cyc = 0;

  // observed traffic
  logic [15:0] lg_ra [64];  logic [31:0] lg_rd [64];  int lg_rn = 0;
  logic [31:0] lg_od [64];  logic [7:0]  lg_oc [64];
  logic        lg_op [64];  logic        lg_ol [64];  int lg_on = 0;
  int err_seen = 0, stall_seen = 0, stall_viol = 0;
  bit prev_stall = 1'b0;
  logic [IDX_W-1:0] prev_rd = '0;

  // expected traffic
  logic [15:0] ex_ra [64];  logic [31:0] ex_rd [64];  int ex_rn = 0;
  logic [31:0] ex_od [64];  logic [7:0]  ex_oc [64];
  logic        ex_op [64];  logic        ex_ol [64];  int ex_on = 0;
  int cmp_r = 0, cmp_o = 0;

  // ready pattern, changed just after the active edge
  always @(posedge clk) begin
    #1;
    cyc++;
    rw_ready = stall_en ? (cyc % 3 == 0) : 1'b1;
    op_ready = stall_en ? (cyc % 3 == 1) : 1'b1;
  end

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && rd_idx != prev_rd) stall_viol++;
      prev_stall = (rw_valid && !rw_ready) || (op_valid && !op_ready);
      if (prev_stall) stall_seen++;
      prev_rd = rd_idx;
      if (rw_valid && rw_ready && lg_rn < 64) begin
        lg_ra[lg_rn] = rw_addr; lg_rd[lg_rn] = rw_data; lg_rn++;
      end
      if (op_valid && op_ready && lg_on < 64) begin
        lg_od[lg_on] = op_data; lg_oc[lg_on] = op_code;
        lg_op[lg_on] = op_pred; lg_ol[lg_on] = op_last; lg_on++;
      end
      if (bad_hdr) err_seen++;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr_regs(input logic [15:0] base, input int n);
    return {2'b00, 14'(n - 1), base};
  endfunction
  function automatic logic [31:0] hdr_oper(input logic [7:0] opc, input int n, input logic pred);
    return {2'b11, 14'(n - 1), opc, 7'd0, pred};
  endfunction

  task automatic put(input logic [31:0] w);
    ring[wp] = w;
    wp = (wp + 1) % RING;
  endtask
  task automatic exp_rw(input logic [15:0] a, input logic [31:0] d);
    ex_ra[ex_rn] = a; ex_rd[ex_rn] = d; ex_rn++;
  endtask
  task automatic exp_op(input logic [7:0] c, input logic p, input logic l, input logic [31:0] d);
    ex_oc[ex_on] = c; ex_op[ex_on] = p; ex_ol[ex_on] = l; ex_od[ex_on] = d; ex_on++;
  endtask

  task automatic publish();
    @(posedge clk); #2;
    wr_idx = IDX_W'(wp);
  endtask

  task automatic drain(input string tag);
    int n = 0;
    @(negedge clk);
    while (rd_idx != wr_idx && n < 500) begin
      @(negedge clk); n++;
    end
    if (n >= 500) check({tag, " drain timeout"}, 64'(rd_idx), 64'(wr_idx));
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    check({tag, " reg-write count"}, 64'(lg_rn), 64'(ex_rn));
    check({tag, " op-word count"},   64'(lg_on), 64'(ex_on));
    for (int i = cmp_r; i < ex_rn && i < lg_rn; i++) begin
      check({tag, " reg addr"}, 64'(lg_ra[i]), 64'(ex_ra[i]));
      check({tag, " reg data"}, 64'(lg_rd[i]), 64'(ex_rd[i]));
    end
    for (int i = cmp_o; i < ex_on && i < lg_on; i++) begin
      check({tag, " op data"}, 64'(lg_od[i]), 64'(ex_od[i]));
      check({tag, " op code"}, 64'(lg_oc[i]), 64'(ex_oc[i]));
      check({tag, " op pred"}, 64'(lg_op[i]), 64'(ex_op[i]));
      check({tag, " op last"}, 64'(lg_ol[i]), 64'(ex_ol[i]));
    end
    cmp_r = ex_rn; cmp_o = ex_on;
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    check("R1 read index", 64'(rd_idx), 64'd0);
    check("R1 rw_valid", 64'(rw_valid), 64'd0);
    check("R1 op_valid", 64'(op_valid), 64'd0);
    check("R1 bad_hdr", 64'(bad_hdr), 64'd0);
  endtask

  // R2: empty ring, including mid-packet
  task automatic t_empty();
    repeat (6) @(negedge clk);
    check("R2 idle index", 64'(rd_idx), 64'd0);
    check("R2 idle writes", 64'(lg_rn), 64'd0);
    put(hdr_regs(16'h0040, 3)); put(32'hA0A0_0001); put(32'hA0A0_0002);
    exp_rw(16'h0040, 32'hA0A0_0001); exp_rw(16'h0041, 32'hA0A0_0002);
    publish();
    repeat (10) @(negedge clk);
    check("R2 partial writes", 64'(lg_rn), 64'd2);
    check("R2 valid low when dry", 64'(rw_valid), 64'd0);
    check("R2 index parked", 64'(rd_idx), 64'd3);
    put(32'hA0A0_0003); exp_rw(16'h0042, 32'hA0A0_0003);
    publish(); drain("R2");
    compare("R2 resume");
  endtask

  // R3
  task automatic t_regburst();
    put(hdr_regs(16'h0100, 4));
    for (int i = 0; i < 4; i++) begin
      put(32'h1100_0000 + i); exp_rw(16'h0100 + 16'(i), 32'h1100_0000 + i);
    end
    put(hdr_regs(16'hFFFE, 3));
    for (int i = 0; i < 3; i++) begin
      put(32'h2200_0000 + i); exp_rw(16'hFFFE + 16'(i), 32'h2200_0000 + i);
    end
    publish(); drain("R3");
    compare("R3 burst");
  endtask

  // R4, R9, R7 (index wraps to 0)
  task automatic t_filler();
    int rn = lg_rn, on = lg_on;
    put(32'h8000_0000); put(32'h8000_1234); put(32'hBFFF_FFFF);
    check("R4 filler ends at ring end", 64'(wp), 64'd0);
    publish(); drain("R4");
    check("R4 no reg write", 64'(lg_rn), 64'(rn));
    check("R4 no op word", 64'(lg_on), 64'(on));
    check("R9 index after fillers", 64'(rd_idx), 64'd0);
    check("R4 no error pulse", 64'(err_seen), 64'd0);
  endtask

  // R5
  task automatic t_oper();
    put(hdr_oper(8'h2D, 3, 1'b1));
    for (int i = 0; i < 3; i++) begin
      put(32'h3300_0000 + i); exp_op(8'h2D, 1'b1, i == 2, 32'h3300_0000 + i);
    end
    put(hdr_oper(8'h10, 1, 1'b0));
    put(32'h4400_00AA); exp_op(8'h10, 1'b0, 1'b1, 32'h4400_00AA);
    publish(); drain("R5");
    compare("R5 oper");
  endtask

  // R6
  task automatic t_reserved();
    put(32'h4003_0041);
    put(hdr_regs(16'h0200, 1)); put(32'h5500_0055);
    exp_rw(16'h0200, 32'h5500_0055);
    publish(); drain("R6");
    check("R6 one error pulse", 64'(err_seen), 64'd1);
    compare("R6 next word is header");
  endtask

  // R7
  task automatic t_wrap();
    while (wp != RING - 2) put(32'h8000_0000);
    put(hdr_oper(8'h77, 3, 1'b0));
    for (int i = 0; i < 3; i++) begin
      put(32'h6600_0000 + i); exp_op(8'h77, 1'b0, i == 2, 32'h6600_0000 + i);
    end
    check("R7 packet crossed ring end", 64'(wp), 64'd2);
    publish(); drain("R7");
    compare("R7 wrap");
    check("R7 index after wrap", 64'(rd_idx), 64'd2);
  endtask

  // R8
  task automatic t_stall();
    stall_en = 1'b1;
    put(hdr_regs(16'h0300, 5));
    for (int i = 0; i < 5; i++) begin
      put(32'h7700_0000 + i); exp_rw(16'h0300 + 16'(i), 32'h7700_0000 + i);
    end
    put(hdr_oper(8'hC3, 2, 1'b1));
    for (int i = 0; i < 2; i++) begin
      put(32'h8800_0000 + i); exp_op(8'hC3, 1'b1, i == 1, 32'h8800_0000 + i);
    end
    publish(); drain("R8");
    stall_en = 1'b0;
    compare("R8 stalled traffic");
    check("R8 stalls exercised", 64'(stall_seen > 0), 64'd1);
    check("R8 index moved while stalled", 64'(stall_viol), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < RING; i++) ring[i] = 32'h8000_0000;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_empty();
    t_regburst();
    t_filler();
    t_oper();
    t_reserved();
    t_wrap();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule